// File: doc/BRIEF.md
# Gated Cycle Counter Group

This block gives each of a set of counting channels a software-selected event source and a gate. Every channel keeps two event counts: one over the cycles in which its gate is high, and one over the whole gate cycle, high and low phases together. Both counts restart when the gate rises. The channel also stamps the time of the latest gate rise and fall from a shared timestamp input, and counts gate rises. Gate generation and time keeping live outside the block. The gate and the timestamp arrive as inputs.

Software reaches everything through a 16-bit register window with a 9-bit word address. A control word holds a soft-clear strobe and a lock bit. While the lock bit is set, reads of the result groups return a copy taken at the moment of locking, so a value spread across several 16-bit words reads back coherent. Counting goes on in the background during that time. A crosspoint table maps any event input to any channel, and several channels may share one input.

Top module: `gcc_group`

## Requirements
- R1: After synchronous reset, every count, time and gate number reads 0. The control word reads 0. Channel c's source select reads c modulo N_IN.
- R2: Writing address 0x0C0+c stores the low SEL_W bits of the write data as channel c's source, and the other bits are ignored. The channel then counts events from hit_in[source].
- R3: In-gate count: each cycle with gate high and the selected event high adds 1. On a gate rising edge the count restarts, and that cycle's event becomes the first count.
- R4: Full-cycle count: each cycle with the selected event high adds 1, whatever the gate level. It restarts on a gate rising edge in the same way as R3.
- R5: On a gate rising edge, the start time takes the value of ts_in in that cycle and the gate number increases by 1.
- R6: On a gate falling edge, the end time takes the value of ts_in in that cycle.
- R7: The in-gate count, the full-cycle count and the gate number stop at 2^CNT_W-1 instead of wrapping.
- R8: A write to address 0x000 with bit 0 set zeroes the counts, times and gate numbers of all channels, and the event in that cycle is not counted. Bit 0 always reads 0, and gate edge detection is not disturbed.
- R9: Control bit 1 is the lock. When it goes from 0 to 1, the group values as they stood before that write are copied. Reads of the groups return the copy while the lock stays set, even across a soft clear. Clearing the lock shows the live values again.
- R10: Channel c's group starts at 0x010+16c. Within a group: +0 in-gate count, +2 full-cycle count, +4 start time, +8 end time, +0xC gate number. Each value has its least significant 16 bits at the lowest address, and +0xE and +0xF read 0. N_CH is at most 11.
- R11: 0x001 reads N_CH. 0x004..0x007 read a 64-bit value whose bit c is channel c's gate level as sampled at the last clock edge. Any other address reads 0, and writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | N_IN | Event inputs, one count per high cycle |
| gate_in | input | N_CH | Gate level per channel |
| ts_in | input | 64 | Current timestamp |
| reg_addr | input | 9 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |

## Verification
The embedded properties rely on four assumptions about the inputs:
- gate_in, hit_in and ts_in are synchronous to clk and are sampled once per edge, so each gate rise and fall spans exactly one cycle of edge detection.
- A write lasts a single cycle.
- The in-gate count never exceeding the full-cycle count follows only from both restarting on the same edge.
- The lock property assumes no new copy can be taken while the lock is already set.

The bench changes every input at the falling clock edge. Between bursts it parks the block with events off, no write and gates held steady. While parked, reads can scan the whole address space without any count or edge moving.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

    localparam int REG_W  = 16;
    localparam int TS_W   = 64;
    localparam int ADDR_W = 9;
    localparam int FLD_W  = 32;

    localparam logic [ADDR_W-1:0] A_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] A_NCH  = 9'h001;
    localparam logic [ADDR_W-1:0] A_GLVL = 9'h004;
    localparam logic [ADDR_W-1:0] A_SEL0 = 9'h0C0;

    typedef struct packed {
        logic [FLD_W-1:0] act;
        logic [FLD_W-1:0] full;
        logic [TS_W-1:0]  t_start;
        logic [TS_W-1:0]  t_end;
        logic [FLD_W-1:0] gnum;
    } chan_res_t;

    typedef enum logic [2:0] {
        F_ACT    = 3'd0,
        F_FULL   = 3'd1,
        F_START0 = 3'd2,
        F_START1 = 3'd3,
        F_END0   = 3'd4,
        F_END1   = 3'd5,
        F_GNUM   = 3'd6,
        F_RSVD   = 3'd7
    } field_e;

    function automatic logic [REG_W-1:0] pick64(logic [TS_W-1:0] v, logic [1:0] k);
        return v[{k, 4'b0000} +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] pick32(logic [FLD_W-1:0] v, logic k);
        return k ? v[31:16] : v[15:0];
    endfunction

    function automatic logic [REG_W-1:0] grp_word(chan_res_t r, logic [3:0] w);
        logic [REG_W-1:0] d;
        case (field_e'(w[3:1]))
            F_ACT:              d = pick32(r.act, w[0]);
            F_FULL:             d = pick32(r.full, w[0]);
            F_START0, F_START1: d = pick64(r.t_start, w[1:0]);
            F_END0, F_END1:     d = pick64(r.t_end, w[1:0]);
            F_GNUM:             d = pick32(r.gnum, w[0]);
            default:            d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gcc_csr.sv
module gcc_csr
    import gcc_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_IN  = 8,
    parameter int SEL_W = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic                          lock_o,
    output logic                          clr_o,
    output logic                          snap_o,
    output logic [N_CH-1:0][SEL_W-1:0]    sel_o
);

    logic                       lock_q;
    logic [N_CH-1:0][SEL_W-1:0] sel_q;
    logic                       ctrl_wr;
    logic                       unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign clr_o   = ctrl_wr && reg_wdata[0];
    assign snap_o  = ctrl_wr && reg_wdata[1] && !lock_q;
    assign lock_o  = lock_q;
    assign sel_o   = sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            for (int c = 0; c < N_CH; c++) begin
                sel_q[c] <= SEL_W'(c % N_IN);
            end
        end else begin
            if (ctrl_wr) begin
                lock_q <= reg_wdata[1];
            end
            for (int c = 0; c < N_CH; c++) begin
                if (reg_wr && (reg_addr == A_SEL0 + ADDR_W'(c))) begin
                    sel_q[c] <= reg_wdata[SEL_W-1:0];
                end
            end
        end
    end

    // R9
    lock_track_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[1]) |=> !lock_o);

endmodule

// File: rtl/gcc_chan.sv
module gcc_chan
    import gcc_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int SEL_W = 3,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  hit_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             gate_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic             clr_i,
    input  logic             snap_i,
    input  logic             lock_i,
    output chan_res_t        res_o,
    output logic             gate_lvl_o
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] act_q, full_q, gnum_q;
    logic [TS_W-1:0]  t_start_q, t_end_q;
    logic             gate_q;
    logic             ev, rise, fall;
    chan_res_t        live, snap_q;

    function automatic logic [CNT_W-1:0] sat_add(logic [CNT_W-1:0] v, logic inc);
        return (inc && v != CMAX) ? v + 1'b1 : v;
    endfunction

    always_comb begin
        ev = 1'b0;
        if (int'(sel_i) < N_IN) begin
            ev = hit_i[sel_i];
        end
    end

    assign rise = gate_i && !gate_q;
    assign fall = !gate_i && gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= 1'b0;
            act_q     <= '0;
            full_q    <= '0;
            gnum_q    <= '0;
            t_start_q <= '0;
            t_end_q   <= '0;
            snap_q    <= '0;
        end else begin
            gate_q <= gate_i;
            if (snap_i) begin
                snap_q <= live;
            end
            if (clr_i) begin
                act_q     <= '0;
                full_q    <= '0;
                gnum_q    <= '0;
                t_start_q <= '0;
                t_end_q   <= '0;
            end else begin
                if (rise) begin
                    act_q     <= CNT_W'(ev);
                    full_q    <= CNT_W'(ev);
                    gnum_q    <= sat_add(gnum_q, 1'b1);
                    t_start_q <= ts_i;
                end else begin
                    if (gate_i) begin
                        act_q <= sat_add(act_q, ev);
                    end
                    full_q <= sat_add(full_q, ev);
                end
                if (fall) begin
                    t_end_q <= ts_i;
                end
            end
        end
    end

    always_comb begin
        live.act     = FLD_W'(act_q);
        live.full    = FLD_W'(full_q);
        live.gnum    = FLD_W'(gnum_q);
        live.t_start = t_start_q;
        live.t_end   = t_end_q;
    end

    assign res_o      = lock_i ? snap_q : live;
    assign gate_lvl_o = gate_q;

    // R3
    act_le_full_chk: assert property (@(posedge clk) disable iff (rst)
        act_q <= full_q);

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (full_q == CMAX && !clr_i && !rise) |=> full_q == CMAX);

    // R5
    start_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !clr_i) |=> t_start_q == $past(ts_i));

    // R5
    gnum_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && !clr_i && gnum_q != CMAX) |=> gnum_q == $past(gnum_q) + 1'b1);

    // R6
    end_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && !clr_i) |=> t_end_q == $past(ts_i));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (act_q == '0 && full_q == '0 && gnum_q == '0));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_i && $past(lock_i)) |-> $stable(res_o));

endmodule

// File: rtl/gcc_rdmux.sv
module gcc_rdmux
    import gcc_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int SEL_W = 3
) (
    input  logic [ADDR_W-1:0]          reg_addr,
    input  chan_res_t [N_CH-1:0]       res_i,
    input  logic                       lock_i,
    input  logic [N_CH-1:0][SEL_W-1:0] sel_i,
    input  logic [N_CH-1:0]            glvl_i,
    output logic [REG_W-1:0]           reg_rdata
);

    logic [TS_W-1:0] glvl64;

    assign glvl64 = TS_W'(glvl_i);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata = {14'b0, lock_i, 1'b0};
        end else if (reg_addr == A_NCH) begin
            reg_rdata = REG_W'(N_CH);
        end else if (reg_addr[8:2] == A_GLVL[8:2]) begin
            reg_rdata = pick64(glvl64, reg_addr[1:0]);
        end
        for (int c = 0; c < N_CH; c++) begin
            if (reg_addr[8:4] == 5'(c + 1)) begin
                reg_rdata = grp_word(res_i[c], reg_addr[3:0]);
            end
            if (reg_addr == A_SEL0 + ADDR_W'(c)) begin
                reg_rdata = REG_W'(sel_i[c]);
            end
        end
    end

endmodule

// File: rtl/gcc_group.sv
module gcc_group
    import gcc_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_IN  = 8,
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   hit_in,
    input  logic [N_CH-1:0]   gate_in,
    input  logic [TS_W-1:0]   ts_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata
);

    localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

    logic                       lock, clr, snap;
    logic [N_CH-1:0][SEL_W-1:0] sel;
    logic [N_CH-1:0]            glvl;
    chan_res_t [N_CH-1:0]       res;

    gcc_csr #(.N_CH(N_CH), .N_IN(N_IN), .SEL_W(SEL_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .lock_o    (lock),
        .clr_o     (clr),
        .snap_o    (snap),
        .sel_o     (sel)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        gcc_chan #(.N_IN(N_IN), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .hit_i      (hit_in),
            .sel_i      (sel[c]),
            .gate_i     (gate_in[c]),
            .ts_i       (ts_in),
            .clr_i      (clr),
            .snap_i     (snap),
            .lock_i     (lock),
            .res_o      (res[c]),
            .gate_lvl_o (glvl[c])
        );
    end

    gcc_rdmux #(.N_CH(N_CH), .SEL_W(SEL_W)) u_rd (
        .reg_addr  (reg_addr),
        .res_i     (res),
        .lock_i    (lock),
        .sel_i     (sel),
        .glvl_i    (glvl),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/tb_gcc_group.sv
module tb_gcc_group;

    localparam int N_CH  = 4;
    localparam int N_IN  = 8;
    localparam int CNT_W = 8;
    localparam int SEL_W = 3;
    localparam logic [31:0] MAXV = 32'((1 << CNT_W) - 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_IN-1:0]   hit_in = '0;
    logic [N_CH-1:0]   gate_in = '0;
    logic [63:0]       ts_in = '0;
    logic [8:0]        reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0]      m_act [N_CH], m_full [N_CH], m_gn [N_CH];
    logic [63:0]      m_ts_s [N_CH], m_ts_e [N_CH];
    logic [31:0]      s_act [N_CH], s_full [N_CH], s_gn [N_CH];
    logic [63:0]      s_ts_s [N_CH], s_ts_e [N_CH];
    logic [SEL_W-1:0] m_sel [N_CH];
    logic [N_CH-1:0]  m_gq = '0;
    logic             m_lock = 1'b0;
    logic [63:0]      ts = 64'h0123_4567_89AB_CDEF;
    logic [N_CH-1:0]  gates = '0;

    gcc_group #(.N_CH(N_CH), .N_IN(N_IN), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .hit_in(hit_in), .gate_in(gate_in), .ts_in(ts_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] sat(logic [31:0] v, logic inc);
        return (inc && v < MAXV) ? v + 1 : v;
    endfunction

    function automatic logic [15:0] w64(logic [63:0] v, logic [1:0] k);
        return v[{k, 4'b0000} +: 16];
    endfunction

    function automatic logic [15:0] exp_word(logic [8:0] a);
        int c;
        logic [31:0] f_act, f_full, f_gn;
        logic [63:0] f_s, f_e;
        if (a == 9'h000) return {14'b0, m_lock, 1'b0};
        if (a == 9'h001) return 16'(N_CH);
        if (a[8:2] == 7'h01) return w64(64'(m_gq), a[1:0]);
        for (int k = 0; k < N_CH; k++) begin
            if (a == 9'h0C0 + 9'(k)) return 16'(m_sel[k]);
        end
        if (a[8:4] >= 5'd1 && a[8:4] <= 5'(N_CH)) begin
            c = int'(a[8:4]) - 1;
            f_act  = m_lock ? s_act[c]  : m_act[c];
            f_full = m_lock ? s_full[c] : m_full[c];
            f_gn   = m_lock ? s_gn[c]   : m_gn[c];
            f_s    = m_lock ? s_ts_s[c] : m_ts_s[c];
            f_e    = m_lock ? s_ts_e[c] : m_ts_e[c];
            case (a[3:0])
                4'h0: return f_act[15:0];
                4'h1: return f_act[31:16];
                4'h2: return f_full[15:0];
                4'h3: return f_full[31:16];
                4'h4, 4'h5, 4'h6, 4'h7: return w64(f_s, a[1:0]);
                4'h8, 4'h9, 4'hA, 4'hB: return w64(f_e, a[1:0]);
                4'hC: return f_gn[15:0];
                4'hD: return f_gn[31:16];
                default: return 16'h0000;
            endcase
        end
        return 16'h0000;
    endfunction

    task automatic step(input logic [N_IN-1:0] h, input logic [N_CH-1:0] g,
                        input logic wr, input logic [8:0] a, input logic [15:0] d);
        logic clr, nl, ev, rise, fall;
        @(negedge clk);
        hit_in = h; gate_in = g; ts_in = ts;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        clr = wr && a == 9'h000 && d[0];
        nl  = (wr && a == 9'h000) ? d[1] : m_lock;
        if (nl && !m_lock) begin
            for (int c = 0; c < N_CH; c++) begin
                s_act[c] = m_act[c]; s_full[c] = m_full[c]; s_gn[c] = m_gn[c];
                s_ts_s[c] = m_ts_s[c]; s_ts_e[c] = m_ts_e[c];
            end
        end
        for (int c = 0; c < N_CH; c++) begin
            ev   = h[m_sel[c]];
            rise = g[c] && !m_gq[c];
            fall = !g[c] && m_gq[c];
            if (clr) begin
                m_act[c] = 0; m_full[c] = 0; m_gn[c] = 0; m_ts_s[c] = 0; m_ts_e[c] = 0;
            end else begin
                if (rise) begin
                    m_act[c] = 32'(ev); m_full[c] = 32'(ev);
                    m_gn[c] = sat(m_gn[c], 1'b1); m_ts_s[c] = ts;
                end else begin
                    if (g[c]) m_act[c] = sat(m_act[c], ev);
                    m_full[c] = sat(m_full[c], ev);
                end
                if (fall) m_ts_e[c] = ts;
            end
            m_gq[c] = g[c];
            if (wr && a == 9'h0C0 + 9'(c)) m_sel[c] = d[SEL_W-1:0];
        end
        m_lock = nl;
        ts = ts + 64'h0001_2345_6789_ABCD;
        gates = g;
        @(negedge clk);
        hit_in = '0; reg_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [15:0] d);
        step('0, gates, 1'b1, a, d);
    endtask

    task automatic chk_all(input string tag);
        logic [15:0] e;
        for (int a = 0; a < 512; a++) begin
            reg_addr = 9'(a);
            #1;
            e = exp_word(9'(a));
            n_chk++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s addr=%03h actual=%04h expected=%04h", tag, a, reg_rdata, e);
            end
        end
    endtask

    task automatic rand_steps(input int n);
        logic [N_CH-1:0] g;
        for (int i = 0; i < n; i++) begin
            g = gates ^ N_CH'($urandom & $urandom);
            step(N_IN'($urandom), g, 1'b0, 9'h000, 16'h0000);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int c = 0; c < N_CH; c++) begin
            m_act[c] = 0; m_full[c] = 0; m_gn[c] = 0; m_ts_s[c] = 0; m_ts_e[c] = 0;
            s_act[c] = 0; s_full[c] = 0; s_gn[c] = 0; s_ts_s[c] = 0; s_ts_e[c] = 0;
            m_sel[c] = SEL_W'(c % N_IN);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset contents
        chk_all("R1 reset");

        // R2: crosspoint writes, high bits dropped, shared source
        wr_reg(9'h0C1, 16'h0005);
        wr_reg(9'h0C2, 16'h0000);
        wr_reg(9'h0C3, 16'hFFFD);
        chk_all("R2 select readback");
        step(8'h20, 4'b0010, 1'b0, 9'h000, 16'h0000);
        step(8'h01, 4'b0110, 1'b0, 9'h000, 16'h0000);
        step(8'h21, 4'b0110, 1'b0, 9'h000, 16'h0000);
        chk_all("R2 R3 R4 R5 routed counting");

        // R3 R4 R5 R6 R10: random gates and events
        rand_steps(300);
        chk_all("R3 R4 R5 R6 R10 random");
        step('0, '0, 1'b0, 9'h000, 16'h0000);
        chk_all("R6 R11 all gates low");

        // R9: lock, background counting, clear under lock, unlock
        wr_reg(9'h000, 16'h0002);
        rand_steps(60);
        chk_all("R9 locked view");
        wr_reg(9'h000, 16'h0003);
        chk_all("R8 R9 clear while locked");
        rand_steps(20);
        wr_reg(9'h000, 16'h0000);
        chk_all("R8 R9 unlocked live");

        // R11: read-only and unmapped writes
        wr_reg(9'h001, 16'hFFFF);
        wr_reg(9'h005, 16'hFFFF);
        wr_reg(9'h01E, 16'hFFFF);
        wr_reg(9'h1F0, 16'hFFFF);
        chk_all("R11 read-only writes ignored");

        // R7: saturation of counts and gate number
        for (int i = 0; i < 300; i++) step('1, 4'b0001, 1'b0, 9'h000, 16'h0000);
        chk_all("R7 count saturation");
        for (int i = 0; i < 600; i++) step('1, (i % 2 == 0) ? 4'b1111 : 4'b0000, 1'b0, 9'h000, 16'h0000);
        chk_all("R7 gate number saturation");

        // R8: soft clear with gates high, event ignored, edge detector kept
        step('0, 4'b1010, 1'b0, 9'h000, 16'h0000);
        step('1, 4'b1010, 1'b1, 9'h000, 16'h0001);
        chk_all("R8 soft clear");
        step('1, 4'b1010, 1'b0, 9'h000, 16'h0000);
        step('1, 4'b1011, 1'b0, 9'h000, 16'h0000);
        chk_all("R8 R10 after clear");

        finish_run();
    end

endmodule